// File: doc/BRIEF.md
# Seven-Segment Centre-Mirrored Space-Vector Sequencer

This block turns three on-times for one switching period (a zero-vector time and the times of two adjacent active vectors, all in clock cycles) into a timed sequence of vector selections. A counter walks through the period and presents, on every cycle, which of seven segments is running and which vector that segment applies: the zero vector, the first active vector or the second active vector. The pattern is symmetric about the centre of the period. The zero-vector time is shared between both edges and the centre, and each active vector is split evenly between the two halves.

On-time inputs are captured only when a period ends, so an upstream calculator may update them at any moment. A one-cycle pulse marks the first cycle of every period so that the calculator can produce the next set of times. Segments of zero length are skipped. The vector code never shows such a segment, even for a single cycle.

The sequencer is a Moore state machine with seven segment states (SEG_Z_HEAD, SEG_A_RISE, SEG_B_RISE, SEG_Z_MID, SEG_B_FALL, SEG_A_FALL, SEG_Z_TAIL). Each cycle it takes exactly one of three transitions:
- HOLD stays in the segment while cycles remain.
- ADVANCE jumps to the next later segment of nonzero length.
- WRAP captures new times and enters the first nonzero segment of the new period.

Top module: `svm_seq7`

## Requirements
- R1: While rst_n is low, seg_idx is 0, vec_code is 0 and period_start is 0. The first period begins on the first clock edge after reset is released.
- R2: With captured times t0, ta and tb, the segment lengths in cycles are as follows:
  - segments 0 and 6: floor(t0/4) each;
  - segments 1 and 5: floor(ta/2) each;
  - segments 2 and 4: floor(tb/2) each;
  - segment 3 (centre): t0 - 2*floor(t0/4) + (ta mod 2) + (tb mod 2).
- R3: Within a period, segments run in ascending order 0 to 6. The vectors they apply are zero, first, second, zero, second, first, zero.
- R4: vec_code encodes 0 for the zero vector, 1 for the first active vector and 2 for the second active vector. The value 3 never appears.
- R5: A period lasts exactly t0 + ta + tb cycles, with no 16-bit wrap of that sum.
- R6: period_start is high for exactly the first cycle of each period and low otherwise.
- R7: The time inputs are sampled only at the clock edge that starts a period. Changes to them at any other time have no effect on the running period.
- R8: A segment of zero length is never shown on seg_idx or vec_code.
- R9: If t0, ta and tb are all zero, the period lasts one cycle, with seg_idx 0, vec_code 0 and period_start high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zero_time | input | 16 | Zero-vector time for the next period, in cycles |
| act_a_time | input | 16 | First active-vector time for the next period, in cycles |
| act_b_time | input | 16 | Second active-vector time for the next period, in cycles |
| seg_idx | output | 3 | Running segment, 0 to 6 |
| vec_code | output | 2 | Vector applied: 0 zero, 1 first active, 2 second active |
| period_start | output | 1 | High on the first cycle of each period |

## Verification
The bench follows every cycle with a model built from the length formulas. Its stimulus includes odd times, zero-length segments, an all-zero period and a period whose total overflows 16 bits. A design that loses the odd remainders would make periods a cycle or two short. A design that truncates the sum would run a much shorter period. A design that steps through empty segments would flash a wrong vector for one cycle. The bench also loads junk times for one cycle in mid-period. A design that samples the inputs continuously, instead of only at the wrap, would adopt those junk times. Any of these faults would change the observed segment sequence or the spacing of the period-start pulses.

// File: rtl/sv7_pkg.sv
package sv7_pkg;
    localparam int NSEG = 7;

    typedef enum logic [2:0] {
        SEG_Z_HEAD = 3'd0,
        SEG_A_RISE = 3'd1,
        SEG_B_RISE = 3'd2,
        SEG_Z_MID  = 3'd3,
        SEG_B_FALL = 3'd4,
        SEG_A_FALL = 3'd5,
        SEG_Z_TAIL = 3'd6
    } seg_e;

    typedef enum logic [1:0] {
        VEC_ZERO   = 2'd0,
        VEC_FIRST  = 2'd1,
        VEC_SECOND = 2'd2
    } vec_e;

    typedef enum logic [1:0] {
        MV_HOLD    = 2'd0,
        MV_ADVANCE = 2'd1,
        MV_WRAP    = 2'd2
    } move_e;
endpackage

// File: rtl/sv7_split.sv
module sv7_split
    import sv7_pkg::*;
#(
    parameter int TW = 16,
    parameter int DW = TW + 2
) (
    input  logic [TW-1:0]                 t_zero,
    input  logic [TW-1:0]                 t_a,
    input  logic [TW-1:0]                 t_b,
    output logic [NSEG-1:0][DW-1:0]       dur
);
    logic [DW-1:0] quarter_z;
    logic [DW-1:0] half_a;
    logic [DW-1:0] half_b;
    logic [DW-1:0] centre;

    always_comb begin
        quarter_z = DW'(t_zero >> 2);
        half_a    = DW'(t_a >> 1);
        half_b    = DW'(t_b >> 1);
        // centre absorbs every remainder so the period sums exactly (R2, R5)
        centre    = DW'(t_zero) - (quarter_z << 1) + DW'(t_a[0]) + DW'(t_b[0]);
    end

    always_comb begin
        dur[0] = quarter_z;
        dur[1] = half_a;
        dur[2] = half_b;
        dur[3] = centre;
        dur[4] = half_b;
        dur[5] = half_a;
        dur[6] = quarter_z;
    end
endmodule

// File: rtl/sv7_seq_fsm.sv
module sv7_seq_fsm
    import sv7_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSEG-1:0][DW-1:0]   new_dur,
    output logic [2:0]                seg_idx_o,
    output logic [1:0]                vec_o,
    output logic                      pstart_o
);
    logic [NSEG-1:0][DW-1:0] dur_q;
    seg_e                    seg_q, seg_d;
    logic [DW-1:0]           cnt_q, cnt_d;
    logic                    pst_q, pst_d;
    logic                    load_en;
    move_e                   move;

    logic                    later_found, first_found;
    logic [2:0]              later_idx, first_idx;

    // search for the nearest later segment of the held times with nonzero length
    always_comb begin
        later_found = 1'b0;
        later_idx   = 3'd0;
        for (int j = NSEG - 1; j >= 0; j--) begin
            if ((j > int'(seg_q)) && (dur_q[j] != '0)) begin
                later_found = 1'b1;
                later_idx   = 3'(j);
            end
        end
    end

    // search for the first nonzero segment of the incoming times
    always_comb begin
        first_found = 1'b0;
        first_idx   = 3'd0;
        for (int j = NSEG - 1; j >= 0; j--) begin
            if (new_dur[j] != '0) begin
                first_found = 1'b1;
                first_idx   = 3'(j);
            end
        end
    end

    // transition choice and next state
    always_comb begin
        if (cnt_q != '0)       move = MV_HOLD;
        else if (later_found)  move = MV_ADVANCE;
        else                   move = MV_WRAP;

        seg_d   = seg_q;
        cnt_d   = cnt_q;
        pst_d   = 1'b0;
        load_en = 1'b0;
        unique case (move)
            MV_HOLD: begin
                cnt_d = cnt_q - 1'b1;
            end
            MV_ADVANCE: begin
                seg_d = seg_e'(later_idx);
                cnt_d = dur_q[later_idx] - 1'b1;
            end
            MV_WRAP: begin
                load_en = 1'b1;
                pst_d   = 1'b1;
                if (first_found) begin
                    seg_d = seg_e'(first_idx);
                    cnt_d = new_dur[first_idx] - 1'b1;
                end else begin
                    seg_d = SEG_Z_HEAD;
                    cnt_d = '0;
                end
            end
            default: begin
                seg_d = SEG_Z_HEAD;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_Z_HEAD;
            cnt_q <= '0;
            pst_q <= 1'b0;
            dur_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
            pst_q <= pst_d;
            if (load_en) dur_q <= new_dur;
        end
    end

    // outputs
    always_comb begin
        seg_idx_o = seg_q;
        pstart_o  = pst_q;
        unique case (seg_q)
            SEG_Z_HEAD, SEG_Z_MID, SEG_Z_TAIL: vec_o = VEC_ZERO;
            SEG_A_RISE, SEG_A_FALL:            vec_o = VEC_FIRST;
            SEG_B_RISE, SEG_B_FALL:            vec_o = VEC_SECOND;
            default:                           vec_o = VEC_ZERO;
        endcase
    end

    // R2: a segment is left only after its count has run out
    a_r2_leave_on_count_end: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q != $past(seg_q)) |-> ($past(cnt_q) == '0));

    // R3: the segment index only falls back at a period start
    a_r3_ascending_order: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_q < $past(seg_q)) |-> pst_q);

    // R6: a period starts only after the previous count has run out
    a_r6_start_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        pst_q |-> ($past(cnt_q) == '0));

    // R8: a newly entered segment has nonzero length unless all are empty
    a_r8_no_empty_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_q != $past(seg_q)) && (dur_q != '0)) |-> (dur_q[seg_q] != '0));
endmodule

// File: rtl/svm_seq7.sv
module svm_seq7
    import sv7_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] zero_time,
    input  logic [TW-1:0] act_a_time,
    input  logic [TW-1:0] act_b_time,
    output logic [2:0]    seg_idx,
    output logic [1:0]    vec_code,
    output logic          period_start
);
    localparam int DW = TW + 2;

    logic [NSEG-1:0][DW-1:0] split_dur;

    sv7_split #(.TW(TW), .DW(DW)) split_i (
        .t_zero (zero_time),
        .t_a    (act_a_time),
        .t_b    (act_b_time),
        .dur    (split_dur)
    );

    sv7_seq_fsm #(.DW(DW)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_dur   (split_dur),
        .seg_idx_o (seg_idx),
        .vec_o     (vec_code),
        .pstart_o  (period_start)
    );

    // R4: code 3 is never produced
    always_comb begin
        if (rst_n) a_r4_vec_legal: assert (vec_code != 2'd3);
    end

    // R1: outputs idle while reset is held
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!rst_n |-> (seg_idx == 3'd0 && !period_start)));
endmodule

// File: tb/svm_seq7_tb_top.sv
module svm_seq7_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int N_RANDOM   = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] zero_time = '0;
    logic [15:0] act_a_time = '0;
    logic [15:0] act_b_time = '0;
    logic [2:0]  seg_idx;
    logic [1:0]  vec_code;
    logic        period_start;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svm_seq7 dut_i (
        .clk(clk), .rst_n(rst_n),
        .zero_time(zero_time), .act_a_time(act_a_time), .act_b_time(act_b_time),
        .seg_idx(seg_idx), .vec_code(vec_code), .period_start(period_start)
    );

    // reference state
    int  rd[7];
    int  rlen, rpos, prev_len, obs_cnt;
    bit  rstarted, have_prev, all_zero;
    int  last_seg;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void latch(input int t0, input int ta, input int tb);
        rd[0] = t0 / 4;  rd[6] = t0 / 4;
        rd[1] = ta / 2;  rd[5] = ta / 2;
        rd[2] = tb / 2;  rd[4] = tb / 2;
        rd[3] = t0 - 2 * (t0 / 4) + (ta % 2) + (tb % 2);
        rlen = t0 + ta + tb;
        all_zero = (rlen == 0);
        if (rlen == 0) rlen = 1;
    endfunction

    function automatic int seg_at(input int pos);
        int acc = 0;
        for (int i = 0; i < 7; i++) begin
            if (pos < acc + rd[i]) return i;
            acc += rd[i];
        end
        return 0;
    endfunction

    function automatic int vec_of(input int s);
        case (s)
            1, 5:    return 1;
            2, 4:    return 2;
            default: return 0;
        endcase
    endfunction

    int st0[10] = '{0, 1, 3, 2, 0, 0, 5, 0, 1001, 65535};
    int sta[10] = '{0, 0, 1, 3, 4, 0, 0, 1, 777, 1};
    int stb[10] = '{0, 0, 1, 5, 0, 7, 0, 1, 513, 1};

    task automatic apply_stim(input int k);
        if (k < 10) begin
            zero_time  = 16'(st0[k]);
            act_a_time = 16'(sta[k]);
            act_b_time = 16'(stb[k]);
        end else begin
            zero_time  = 16'($urandom % 61);
            act_a_time = 16'($urandom % 41);
            act_b_time = 16'($urandom % 41);
        end
    endtask

    initial begin
        int  stim_k;
        bit  wrap;
        int  es;
        string tg;
        void'($urandom(32'h5EED));
        rstarted = 0; have_prev = 0; obs_cnt = 0; last_seg = 0;
        stim_k = 0;
        apply_stim(stim_k);
        stim_k++;
        repeat (3) begin
            @(negedge clk);
            chk(seg_idx == 3'd0, "R1 seg_idx in reset", int'(seg_idx), 0);
            chk(vec_code == 2'd0, "R1 vec_code in reset", int'(vec_code), 0);
            chk(period_start == 1'b0, "R1 period_start in reset", int'(period_start), 0);
        end
        rst_n = 1'b1;
        while (stim_k <= 10 + N_RANDOM) begin
            @(negedge clk);
            wrap = 0;
            if (!rstarted || rpos == rlen - 1) begin
                latch(int'(zero_time), int'(act_a_time), int'(act_b_time));
                rpos = 0; rstarted = 1; wrap = 1;
            end else begin
                rpos++;
            end
            es = seg_at(rpos);
            tg = all_zero ? "R9" : "R2/R7";
            chk(int'(seg_idx) == es, {tg, " seg_idx"}, int'(seg_idx), es);
            chk(int'(vec_code) == vec_of(es), "R3/R4 vec_code", int'(vec_code), vec_of(es));
            chk(period_start == wrap, "R6 period_start", int'(period_start), int'(wrap));
            if (int'(seg_idx) != last_seg && !all_zero)
                chk(rd[seg_idx] != 0, "R8 entered empty segment", int'(seg_idx), -1);
            last_seg = int'(seg_idx);
            if (period_start) begin
                if (have_prev) chk(obs_cnt == prev_len, "R5 period length", obs_cnt, prev_len);
                have_prev = 1; prev_len = rlen; obs_cnt = 1;
            end else begin
                obs_cnt++;
            end
            // stimulus for the next period; junk for one cycle in long periods (R7)
            if (wrap) begin
                if (rlen >= 3) begin
                    zero_time  = 16'($urandom);
                    act_a_time = 16'($urandom);
                    act_b_time = 16'($urandom);
                end else begin
                    apply_stim(stim_k);
                    stim_k++;
                end
            end else if (rpos == 1) begin
                apply_stim(stim_k);
                stim_k++;
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule